// File: doc/BRIEF.md
# UART Automatic Baud Rate Detector

This block learns the bit rate of a serial host before any UART traffic is understood. Once started, it listens to the raw receive pin while the host keeps sending the null character (0x00) at its chosen rate. A null character keeps the line low for nine bit times in a row: the start bit and eight zero data bits. The block times that whole low stretch in system clock cycles. It checks the result against legal bounds and waits until two measurements in a row agree. It then turns the low time into a divisor for the UART's rate generator, strobes it out, and asks the transmitter to send one 0x00 byte back to the host as the acknowledgement. The divisor then stays fixed until the next reset, because only one lock is attempted per reset.

The divisor is the nearest whole number of system clocks per UART sample tick, where the UART takes `OVS` ticks per bit. The legal low-time window (`MIN_LOW` to `MAX_LOW` cycles) sets which host rates can lock at a given clock. For example, with `OVS` = 16 and a 20 MHz clock, a 19200 bps host gives a low time of about 9375 cycles and a 1200 bps host about 150000 cycles.

The controller is a six-state machine. AB_IDLE waits for `start` and moves to AB_HUNT. AB_HUNT waits for a falling edge that comes after a high sample and moves to AB_TIME. AB_TIME counts low cycles and moves to AB_JUDGE when the line rises. AB_JUDGE has three exits: a rejected sample returns to AB_HUNT and drops the reference, a first or mismatching sample returns to AB_HUNT and becomes the new reference, and a matching sample goes to AB_LOCK. AB_LOCK lasts one cycle and always moves to AB_HOLD. AB_HOLD never exits.

Top module: `uart_autobaud`

## Requirements
- R1: After reset, `divisor` is 0 and `div_valid`, `ack_req` and `done` are low.
- R2: Activity on `rx_pin` before `start` is asserted has no effect on any output.
- R3: Lock needs two consecutive accepted low times, an earlier reference A and a newer B, with |B - A| <= floor(A/16). A single measurement never locks.
- R4: At lock, `div_valid` and `ack_req` are high together for exactly one cycle, and `done` is high from the next cycle on. `ack_req` asks the transmitter to send the byte 0x00.
- R5: The divisor is round(B / (9*OVS)), computed from the newer low time B, with an exact half rounding up.
- R6: When a newer accepted low time falls outside the tolerance, it replaces the reference and no lock occurs.
- R7: A low time shorter than `MIN_LOW` cycles is rejected. A low time of exactly `MIN_LOW` is accepted.
- R8: A low time longer than `MAX_LOW` cycles is rejected, with the counter saturating at `MAX_LOW`+1. A low time of exactly `MAX_LOW` is accepted.
- R9: After lock, `divisor` and `done` hold, and neither further `rx_pin` traffic nor `start` causes another `div_valid` or `ack_req`.
- R10: A low stretch is timed only if the synchronized line was seen high after `start`. A low that began before `start` is not measured.
- R11: A rejected sample clears the reference, so the next accepted sample cannot lock on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pin | input | 1 | Raw serial receive line, idle high |
| start | input | 1 | Begins detection when seen in AB_IDLE |
| divisor | output | DIV_W | Locked clocks-per-sample-tick value |
| div_valid | output | 1 | One-cycle strobe when `divisor` is loaded |
| done | output | 1 | High once detection has finished |
| ack_req | output | 1 | One-cycle request to transmit 0x00 |

## Verification
The bench builds the block with `OVS` = 1, `MIN_LOW` = 90 and `MAX_LOW` = 2700. With these values the divisor equals the bit time in clocks, so a bit time of 100 clocks is expected to give 100. Short characters keep the run quick. They also put both window edges (90/89 and 2700/2701), the exact 1/16 tolerance boundary (900 against 956 and 957) and the round-half-up split (904 against 905) within a few thousand cycles each.

// File: rtl/abd_pkg.sv
package abd_pkg;
    typedef enum logic [2:0] {
        AB_IDLE,
        AB_HUNT,
        AB_TIME,
        AB_JUDGE,
        AB_LOCK,
        AB_HOLD
    } ab_state_e;
endpackage

// File: rtl/abd_sync.sv
module abd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pin,
    output logic rx_s,
    output logic fall
);
    logic meta_q;
    logic last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            rx_s   <= 1'b1;
            last_q <= 1'b1;
        end else begin
            meta_q <= rx_pin;
            rx_s   <= meta_q;
            last_q <= rx_s;
        end
    end

    // a fall is only reported when the preceding sample was idle-high
    assign fall = last_q & ~rx_s;
endmodule

// File: rtl/abd_lowcnt.sv
module abd_lowcnt #(
    parameter int CNT_W = 18,
    parameter int SAT   = 160001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= CNT_W'(1);
        else if (inc && count != SAT_V)
            count <= count + 1'b1;
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= SAT_V);
    p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == SAT_V && !load) |=> count == SAT_V);
endmodule

// File: rtl/abd_ratio.sv
module abd_ratio #(
    parameter int CNT_W = 18,
    parameter int DIV   = 144
) (
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] ref_c,
    output logic             close,
    output logic [CNT_W:0]   div
);
    localparam logic [CNT_W:0] DV   = (CNT_W+1)'(DIV);
    localparam logic [CNT_W:0] HALF = (CNT_W+1)'(DIV / 2);

    logic [CNT_W:0] diff;
    logic [CNT_W:0] sum;

    always_comb begin
        if (cur >= ref_c)
            diff = {1'b0, cur} - {1'b0, ref_c};
        else
            diff = {1'b0, ref_c} - {1'b0, cur};
        close = diff <= {5'b0, ref_c[CNT_W-1:4]};
        sum   = {1'b0, cur} + HALF;
        div   = sum / DV;
    end
endmodule

// File: rtl/uart_autobaud.sv
module uart_autobaud #(
    parameter int OVS     = 16,
    parameter int MIN_LOW = 900,
    parameter int MAX_LOW = 160000,
    parameter int CNT_W   = $clog2(MAX_LOW + 2),
    parameter int DIV_W   = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_pin,
    input  logic             start,
    output logic [DIV_W-1:0] divisor,
    output logic             div_valid,
    output logic             done,
    output logic             ack_req
);
    import abd_pkg::*;

    localparam int SAT     = MAX_LOW + 1;
    localparam int DEN     = 9 * OVS;
    localparam int MIN_DIV = MIN_LOW / DEN;

    ab_state_e        state, state_nx;
    logic             rx_s, fall;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] ref_q;
    logic             have_ref;
    logic             close;
    logic [CNT_W:0]   div_c;
    logic             reject;

    abd_sync u_sync (
        .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .rx_s(rx_s), .fall(fall)
    );

    abd_lowcnt #(.CNT_W(CNT_W), .SAT(SAT)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .load(state == AB_HUNT && fall),
        .inc(state == AB_TIME && !rx_s),
        .count(count)
    );

    abd_ratio #(.CNT_W(CNT_W), .DIV(DEN)) u_ratio (
        .cur(count), .ref_c(ref_q), .close(close), .div(div_c)
    );

    assign reject = (count < CNT_W'(MIN_LOW)) || (count > CNT_W'(MAX_LOW));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= AB_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            AB_IDLE:  if (start) state_nx = AB_HUNT;
            AB_HUNT:  if (fall) state_nx = AB_TIME;
            AB_TIME:  if (rx_s) state_nx = AB_JUDGE;
            AB_JUDGE: state_nx = (!reject && have_ref && close) ? AB_LOCK : AB_HUNT;
            AB_LOCK:  state_nx = AB_HOLD;
            AB_HOLD:  state_nx = AB_HOLD;
            default:  state_nx = AB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_ref <= 1'b0;
            ref_q    <= '0;
            divisor  <= '0;
        end else if (state == AB_JUDGE) begin
            if (reject) begin
                have_ref <= 1'b0;
            end else if (have_ref && close) begin
                divisor <= DIV_W'(div_c);
            end else begin
                ref_q    <= count;
                have_ref <= 1'b1;
            end
        end
    end

    always_comb begin
        div_valid = (state == AB_LOCK);
        ack_req   = (state == AB_LOCK);
        done      = (state == AB_HOLD);
    end

    p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        div_valid |=> (!div_valid && done));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(divisor) && !ack_req));
    p_div_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_valid |-> (divisor >= DIV_W'(MIN_DIV)));
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == AB_IDLE) |-> (divisor == '0 && !done));
endmodule

// File: tb/sim_uart_autobaud.sv
module sim_uart_autobaud;
    localparam int OVS = 1, MINL = 90, MAXL = 2700;
    localparam int CW = $clog2(MAXL + 2), DW = CW + 1;
    localparam int GAP = 60;

    logic clk = 1'b0, rst_n = 1'b0, rx_pin = 1'b1, start = 1'b0;
    logic [DW-1:0] divisor;
    logic div_valid, done, ack_req;
    int n_chk = 0, n_fail = 0, vcount = 0, ack_mis = 0;
    logic [DW-1:0] vdiv = '0;

    always #5 clk = ~clk;

    uart_autobaud #(.OVS(OVS), .MIN_LOW(MINL), .MAX_LOW(MAXL)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .start(start),
        .divisor(divisor), .div_valid(div_valid), .done(done), .ack_req(ack_req)
    );

    always @(negedge clk) begin
        if (div_valid) begin
            vcount = vcount + 1;
            vdiv   = divisor;
        end
        if (div_valid != ack_req) ack_mis = ack_mis + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rx_pin = 1'b1; start = 1'b0;
        repeat (4) @(negedge clk);
        vcount = 0; ack_mis = 0; vdiv = '0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic kick();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic send(input int low);
        @(negedge clk); rx_pin = 1'b0;
        repeat (low) @(negedge clk);
        rx_pin = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic expect_lock(input string tag, input int d);
        check(done == 1'b1, {tag, " done"}, int'(done), 1);
        check(vcount == 1, {tag, " one valid strobe"}, vcount, 1);
        check(int'(vdiv) == d && int'(divisor) == d, {tag, " divisor"}, int'(divisor), d);
        check(ack_mis == 0, {tag, " ack with valid"}, ack_mis, 0);
    endtask

    task automatic expect_none(input string tag);
        check(done == 1'b0 && vcount == 0, {tag, " no lock"}, vcount + int'(done), 0);
    endtask

    task automatic t_reset();
        do_reset();
        check(divisor == '0 && !div_valid && !done && !ack_req, "R1 reset state",
              int'(divisor) + int'(done) + int'(div_valid) + int'(ack_req), 0);
    endtask

    task automatic t_prestart();
        do_reset();
        send(900); send(900); send(900);
        expect_none("R2 before start");
        check(divisor == '0, "R2 divisor idle", int'(divisor), 0);
        kick(); send(900); send(900);
        expect_lock("R2 after start", 100);
    endtask

    task automatic t_basic();
        do_reset(); kick();
        send(900);
        expect_none("R3 single sample");
        send(900);
        expect_lock("R3 R4 basic", 100);
        @(negedge clk);
        check(ack_req == 1'b0 && div_valid == 1'b0, "R4 strobe one cycle",
              int'(ack_req) + int'(div_valid), 0);
    endtask

    task automatic t_hold();
        send(450); send(450); kick(); send(450);
        check(int'(divisor) == 100 && done, "R9 divisor held", int'(divisor), 100);
        check(vcount == 1, "R9 no second strobe", vcount, 1);
    endtask

    task automatic t_tol();
        do_reset(); kick();
        send(900); send(956);
        expect_lock("R3 tolerance edge", 106);
    endtask

    task automatic t_ref();
        do_reset(); kick();
        send(900); send(957);
        expect_none("R6 out of tolerance");
        send(957);
        expect_lock("R6 new reference", 106);
    endtask

    task automatic t_round();
        do_reset(); kick();
        send(904); send(904);
        expect_lock("R5 round down", 100);
        do_reset(); kick();
        send(905); send(905);
        expect_lock("R5 round up", 101);
    endtask

    task automatic t_short();
        do_reset(); kick();
        send(89); send(89);
        expect_none("R7 below min");
        send(90); send(90);
        expect_lock("R7 min accepted", 10);
    endtask

    task automatic t_long();
        do_reset(); kick();
        send(2701); send(2701);
        expect_none("R8 above max");
        send(2700); send(2700);
        expect_lock("R8 max accepted", 300);
    endtask

    task automatic t_break();
        do_reset(); kick();
        send(900); send(81); send(900);
        expect_none("R11 pair broken");
        send(900);
        expect_lock("R11 relock", 100);
    endtask

    task automatic t_qual();
        do_reset();
        @(negedge clk); rx_pin = 1'b0;
        repeat (500) @(negedge clk);
        kick();
        repeat (900) @(negedge clk);
        rx_pin = 1'b1;
        repeat (GAP) @(negedge clk);
        send(900);
        expect_none("R10 early low ignored");
        send(900);
        expect_lock("R10 lock", 100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        t_reset();
        t_prestart();
        t_basic();
        t_hold();
        t_tol();
        t_ref();
        t_round();
        t_short();
        t_long();
        t_break();
        t_qual();
        summary();
    end
endmodule